// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block is the slave end of an 8-bit multiplexed address/data bus. Every bus cycle begins with an address phase and ends with a data phase. The falling edge of the address strobe captures the address byte and a bank-select line. During the data phase the block either reads one byte from, or writes one byte to, a 256-location register space. Locations 0 to 127 of bank 0 hold the clock/control bytes followed by general storage. Bank 1 is a second 128-byte storage area.

A static mode pin chooses how the two data-phase control pins are interpreted.

- **Level-plus-strobe mode** (mode pin high): the direction pin gives the transfer direction as a level, and the data strobe is active high.
- **Split-strobe mode** (mode pin low): the data strobe acts as an active-low read strobe, and the direction pin acts as an active-low write strobe.

All bus pins are synchronised into a fast system clock. The register file sits behind single-cycle request pulses on the register side. Drive of the shared bus is shown through an output-enable signal.

The state machine has five states:

- `S_BOOT`: captures the mode pin.
- `S_IDLE`: waits for an address strobe.
- `S_ADDR`: holds an address, and relatches it on a further strobe.
- `S_READ`: drives the bus.
- `S_WRITE`: waits for the write-latching edge.

It has these transitions:

- BOOT→IDLE: always.
- IDLE→ADDR: on an address-strobe fall.
- ADDR→ADDR: on another address-strobe fall.
- ADDR→READ: on a selected read start.
- ADDR→WRITE: on a selected write start.
- READ→IDLE: when the read strobe ends.
- WRITE→IDLE: on the write-latching edge.

Top module: `mbus_slave`

## Requirements
- R1: On each falling edge of the address strobe, the register index is captured as {bank select, address bits 6:0`}`. Address bit 7 is ignored. The capture happens whatever the chip-select level is at that moment.
- R2: In level-plus-strobe mode, a rising data strobe with the direction pin high and chip select low gives exactly one read request. The output enable then stays asserted until the data strobe falls, and the driven byte equals the register-side read data.
- R3: In level-plus-strobe mode, when the direction pin is low, the byte on the bus at the falling data strobe is issued as exactly one write request to the captured index.
- R4: In split-strobe mode, a falling data strobe with chip select low gives exactly one read request. The output enable stays asserted until the data strobe rises again.
- R5: In split-strobe mode, the direction pin is an active-low write strobe. The byte present at its rising edge is issued as exactly one write request.
- R6: If chip select is high during the data phase, the cycle produces no request and no output enable.
- R7: While write-protect is high, no write request is issued to any index. Reads still work.
- R8: Index 0x0C in bank 0 is the read-only status byte. A write to it produces no write request. A read of it raises the flag-clear pulse in the same cycle as the read request. No other index raises that pulse.
- R9: While reset is low, no request is issued and the output enable stays low, whatever the bus does.
- R10: The mode pin is captured in the first cycle after reset. Later changes to it have no effect until the next reset.
- R11: A read request and a write request are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = level-plus-strobe mode, 0 = split-strobe mode |
| as_i | input | 1 | Address strobe; the address is captured on its falling edge |
| ds_i | input | 1 | Data strobe (active high in mode 1, active-low read in mode 0) |
| rw_i | input | 1 | Direction level (mode 1) or active-low write strobe (mode 0) |
| cs_n_i | input | 1 | Active-low chip select |
| ext_i | input | 1 | Bank select, captured with the address |
| ad_i | input | 8 | Bus byte as seen by the block |
| wp_i | input | 1 | Write-protect from the power-fail monitor |
| rd_data_i | input | 8 | Read data from the register file at `req_idx_o` |
| ad_o | output | 8 | Byte driven onto the bus |
| ad_oe_o | output | 1 | Bus drive enable |
| req_idx_o | output | 8 | Captured register index {bank, offset} |
| rd_req_o | output | 1 | One-cycle read request |
| wr_req_o | output | 1 | One-cycle write request |
| wr_data_o | output | 8 | Write data that goes with `wr_req_o` |
| clr_flags_o | output | 1 | One-cycle flag-clear pulse on a status-byte read |

## Verification
In each mode, all 256 combinations of bank and offset are written and then read back. Bit 7 of the address is toggled by a pattern, so a decoder that leaks it, a swapped bank bit or a misplaced status decode shows up as a wrong index or a wrong pulse. The write data varies arithmetically with the index, which exposes a wrong sampling edge or a wrong data source.

Further patterns cover these cases:

- chip select high only in the address phase, which must still work;
- chip select high in the data phase, which must do nothing;
- writes under write-protect;
- bus activity while reset is held;
- a mode pin flipped after reset.

Each of these separates a correct select, protect or mode gating from one that is missing or misplaced.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;
    typedef enum logic [2:0] {
        S_BOOT,
        S_IDLE,
        S_ADDR,
        S_READ,
        S_WRITE
    } mbus_state_e;

    // bit positions inside the synchronised bus vector
    localparam int SIG_AS  = 0;
    localparam int SIG_DS  = 1;
    localparam int SIG_RW  = 2;
    localparam int SIG_CS  = 3;
    localparam int SIG_EXT = 4;
    localparam int SIG_AD  = 5;
    localparam int CTRL_W  = 5;
endpackage

// File: rtl/mbus_sync.sv
`timescale 1ns/1ps
module mbus_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/mbus_edges.sv
`timescale 1ns/1ps
module mbus_edges #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= cur;
    end

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;
endmodule

// File: rtl/mbus_decode.sv
`timescale 1ns/1ps
module mbus_decode #(
    parameter int AW = 7,
    parameter logic [AW-1:0] STATUS_OFS = 7'h0C
) (
    input  logic        bank,
    input  logic [AW-1:0] ofs,
    input  logic        wp,
    output logic        is_status,
    output logic        wr_ok
);
    always_comb begin
        is_status = !bank && (ofs == STATUS_OFS);
        wr_ok     = !wp && !is_status;
    end
endmodule

// File: rtl/mbus_slave.sv
`timescale 1ns/1ps
module mbus_slave #(
    parameter int DW = 8,
    parameter int AW = 7,
    parameter int SYNC_STAGES = 2,
    parameter logic [AW-1:0] STATUS_OFS = 7'h0C,
    localparam int IW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          as_i,
    input  logic          ds_i,
    input  logic          rw_i,
    input  logic          cs_n_i,
    input  logic          ext_i,
    input  logic [DW-1:0] ad_i,
    input  logic          wp_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic [IW-1:0] req_idx_o,
    output logic          rd_req_o,
    output logic          wr_req_o,
    output logic [DW-1:0] wr_data_o,
    output logic          clr_flags_o
);
    import mbus_pkg::*;

    localparam int SW = CTRL_W + DW;
    localparam logic [SW-1:0] SYNC_RST = {{(SW-1){1'b0}}, 1'b1} << SIG_CS;

    mbus_state_e st, st_nx;

    logic [SW-1:0] bus_s;
    logic [1:0]    str_rise, str_fall;
    logic          as_prev, as_fall;
    logic          ds_rise, ds_fall, rw_rise, rw_fall;
    logic          rw_s, cs_sel, ext_s;
    logic [DW-1:0] ad_s;
    logic          mode_q;
    logic          start_rd, start_wr, end_rd, commit_wr;
    logic          is_status, wr_ok;
    logic [IW-1:0] idx_q;
    logic          rd_q, wr_q, clr_q;
    logic [DW-1:0] wdat_q;

    // synchronise every bus pin through the same pipeline so data aligns with strobes
    mbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({ad_i, ext_i, cs_n_i, rw_i, ds_i, as_i}),
        .q (bus_s)
    );

    mbus_edges #(.W(2), .RST_VAL(2'b00)) u_edges (
        .clk (clk),
        .rst_n (rst_n),
        .cur ({bus_s[SIG_RW], bus_s[SIG_DS]}),
        .rise (str_rise),
        .fall (str_fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) as_prev <= 1'b0;
        else        as_prev <= bus_s[SIG_AS];
    end

    assign as_fall = as_prev && !bus_s[SIG_AS];
    assign ds_rise = str_rise[0];
    assign ds_fall = str_fall[0];
    assign rw_rise = str_rise[1];
    assign rw_fall = str_fall[1];
    assign rw_s    = bus_s[SIG_RW];
    assign cs_sel  = !bus_s[SIG_CS];
    assign ext_s   = bus_s[SIG_EXT];
    assign ad_s    = bus_s[SIG_AD +: DW];

    mbus_decode #(.AW(AW), .STATUS_OFS(STATUS_OFS)) u_dec (
        .bank (idx_q[IW-1]),
        .ofs (idx_q[AW-1:0]),
        .wp (wp_i),
        .is_status (is_status),
        .wr_ok (wr_ok)
    );

    // mode-dependent interpretation of the data-phase pins
    always_comb begin
        if (mode_q) begin
            start_rd  = ds_rise && rw_s && cs_sel;
            start_wr  = ds_rise && !rw_s && cs_sel;
            end_rd    = ds_fall;
            commit_wr = ds_fall;
        end else begin
            start_rd  = ds_fall && cs_sel;
            start_wr  = rw_fall && cs_sel && !ds_fall;
            end_rd    = ds_rise;
            commit_wr = rw_rise;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_BOOT:  st_nx = S_IDLE;
            S_IDLE:  if (as_fall) st_nx = S_ADDR;
            S_ADDR: begin
                if (as_fall)       st_nx = S_ADDR;
                else if (start_rd) st_nx = S_READ;
                else if (start_wr) st_nx = S_WRITE;
            end
            S_READ:  if (end_rd) st_nx = S_IDLE;
            S_WRITE: if (commit_wr) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_BOOT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            idx_q  <= '0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            clr_q  <= 1'b0;
            wdat_q <= '0;
        end else begin
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            clr_q <= 1'b0;
            if (st == S_BOOT) begin
                mode_q <= mode_i;
            end
            if (as_fall && (st == S_IDLE || st == S_ADDR)) begin
                idx_q <= {ext_s, ad_s[AW-1:0]};
            end
            if (st == S_ADDR && !as_fall && start_rd) begin
                rd_q  <= 1'b1;
                clr_q <= is_status;
            end
            if (st == S_WRITE && commit_wr && cs_sel && wr_ok) begin
                wr_q   <= 1'b1;
                wdat_q <= ad_s;
            end
        end
    end

    assign ad_oe_o     = (st == S_READ);
    assign ad_o        = ad_oe_o ? rd_data_i : '0;
    assign req_idx_o   = idx_q;
    assign rd_req_o    = rd_q;
    assign wr_req_o    = wr_q;
    assign wr_data_o   = wdat_q;
    assign clr_flags_o = clr_q;
endmodule

// File: rtl/mbus_slave_chk.sv
`timescale 1ns/1ps
module mbus_slave_chk #(
    parameter int IW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wp_i,
    input logic                  rd_req_o,
    input logic                  wr_req_o,
    input logic                  clr_flags_o,
    input logic                  ad_oe_o,
    input logic [IW-1:0]         req_idx_o,
    input logic                  mode_q,
    input mbus_pkg::mbus_state_e st
);
    import mbus_pkg::*;

    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_o && wr_req_o));

    a_r7_wp_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> $past(!wp_i));

    a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flags_o |-> rd_req_o);

    a_r2_drive_starts_with_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe_o) |-> rd_req_o);

    a_r1_index_held_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe_o && $past(ad_oe_o)) |-> $stable(req_idx_o));

    a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_BOOT && $past(st) != S_BOOT) |-> $stable(mode_q));

    a_r9_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!rd_req_o && !wr_req_o && !ad_oe_o));
endmodule

bind mbus_slave mbus_slave_chk #(.IW(IW)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .wp_i (wp_i),
    .rd_req_o (rd_req_o),
    .wr_req_o (wr_req_o),
    .clr_flags_o (clr_flags_o),
    .ad_oe_o (ad_oe_o),
    .req_idx_o (req_idx_o),
    .mode_q (mode_q),
    .st (st)
);

// File: tb/sim_mbus_slave.sv
`timescale 1ns/1ps
module sim_mbus_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic mode_pin = 1'b1;
    logic as_i = 1'b0, ds_i = 1'b0, rw_i = 1'b1, cs_n_i = 1'b1, ext_i = 1'b0;
    logic [7:0] ad_i = 8'h00;
    logic wp_i = 1'b0;
    logic [7:0] rd_data_i;
    logic [7:0] ad_o, req_idx_o, wr_data_o;
    logic ad_oe_o, rd_req_o, wr_req_o, clr_flags_o;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0, rd_cnt = 0, clr_cnt = 0, both_cnt = 0;
    logic [7:0] wr_idx, wr_dat, rd_idx;
    logic seq_mot = 1'b1;

    always #2.5 clk = ~clk;

    // bench register model: read data is a fixed function of the index
    assign rd_data_i = req_idx_o ^ 8'hA5;

    mbus_slave u0 (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_pin), .as_i (as_i), .ds_i (ds_i),
        .rw_i (rw_i), .cs_n_i (cs_n_i), .ext_i (ext_i), .ad_i (ad_i), .wp_i (wp_i),
        .rd_data_i (rd_data_i), .ad_o (ad_o), .ad_oe_o (ad_oe_o), .req_idx_o (req_idx_o),
        .rd_req_o (rd_req_o), .wr_req_o (wr_req_o), .wr_data_o (wr_data_o),
        .clr_flags_o (clr_flags_o)
    );

    always @(posedge clk) begin
        if (wr_req_o) begin wr_cnt++; wr_idx = req_idx_o; wr_dat = wr_data_o; end
        if (rd_req_o) begin rd_cnt++; rd_idx = req_idx_o; end
        if (clr_flags_o) clr_cnt++;
        if (rd_req_o && wr_req_o) both_cnt++;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0;
        mode_pin = m;
        seq_mot = m;
        as_i = 1'b0; cs_n_i = 1'b1; rw_i = 1'b1;
        ds_i = m ? 1'b0 : 1'b1;
        cyc(4);
        rst_n = 1'b1;
        cyc(4);
    endtask

    // one complete bus cycle in the style given by seq_mot
    task automatic bus_access(input logic wr, input logic [7:0] idx, input logic a7,
                              input logic [7:0] data, input logic cs_a, input logic cs_d,
                              input logic exp_act, input logic exp_clr, input string req);
        int w0 = wr_cnt, r0 = rd_cnt, c0 = clr_cnt;
        logic exp_oe = !wr && exp_act;
        ext_i = idx[7];
        ad_i = {a7, idx[6:0]};
        cs_n_i = cs_a;
        as_i = 1'b1;
        if (seq_mot) rw_i = !wr;
        cyc(4);
        as_i = 1'b0;
        cyc(4);
        cs_n_i = cs_d;
        if (wr) ad_i = data;
        if (seq_mot) ds_i = 1'b1;
        else if (wr) rw_i = 1'b0;
        else ds_i = 1'b0;
        cyc(4);
        if (!wr) begin
            check(ad_oe_o == exp_oe, {req, " drive enable in read"}, ad_oe_o, exp_oe);
            if (exp_oe)
                check(ad_o == (idx ^ 8'hA5), {req, " read byte"}, ad_o, idx ^ 8'hA5);
        end
        if (seq_mot) ds_i = 1'b0;
        else if (wr) rw_i = 1'b1;
        else ds_i = 1'b1;
        cyc(4);
        cs_n_i = 1'b1;
        rw_i = 1'b1;
        cyc(2);
        check(ad_oe_o == 1'b0, {req, " drive released"}, ad_oe_o, 0);
        check(wr_cnt - w0 == int'(wr && exp_act), {req, " write count"}, wr_cnt - w0, int'(wr && exp_act));
        check(rd_cnt - r0 == int'(!wr && exp_act), {req, " read count"}, rd_cnt - r0, int'(!wr && exp_act));
        if (wr && exp_act) begin
            check(wr_idx == idx, {req, " write index"}, wr_idx, idx);
            check(wr_dat == data, {req, " write data"}, wr_dat, data);
        end
        if (!wr && exp_act) begin
            check(rd_idx == idx, {req, " read index"}, rd_idx, idx);
            check(clr_cnt - c0 == int'(exp_clr), {req, " flag clear"}, clr_cnt - c0, int'(exp_clr));
        end
    endtask

    task automatic sweep(input string rq_wr, input string rq_rd);
        for (int k = 0; k < 256; k++) begin
            logic [7:0] idx = 8'(k);
            logic st8 = (idx == 8'h0C);
            logic a7 = idx[0] ^ idx[3];
            logic [7:0] dat = 8'(k * 37 + 5);
            bus_access(1'b1, idx, a7, dat, 1'b0, 1'b0, !st8, 1'b0, st8 ? "R8 R1 status write" : {rq_wr, " R1"});
            bus_access(1'b0, idx, !a7, dat, 1'b0, 1'b0, 1'b1, st8, st8 ? "R8 status read" : {rq_rd, " R1"});
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        cyc(2);
        check(!ad_oe_o && !rd_req_o && !wr_req_o && !clr_flags_o, "R9 reset state", ad_oe_o, 0);
        do_reset(1'b1);
        sweep("R3 level-mode write", "R2 level-mode read");
        do_reset(1'b0);
        sweep("R5 split-mode write", "R4 split-mode read");

        // R6: deselected data phase in both modes
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            bus_access(1'b1, 8'h21, 1'b0, 8'h66, 1'b0, 1'b1, 1'b0, 1'b0, "R6 deselected write");
            bus_access(1'b0, 8'h21, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R6 deselected read");
            // R1: select high only during address phase
            bus_access(1'b1, 8'h93, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, "R1 address ignores select");
            bus_access(1'b0, 8'h93, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R1 address ignores select");
            // R7: write-protect
            wp_i = 1'b1;
            bus_access(1'b1, 8'h05, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, "R7 protected write");
            bus_access(1'b1, 8'hC4, 1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, "R7 protected write");
            bus_access(1'b0, 8'h0C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R7 read under protect");
            wp_i = 1'b0;
        end

        // R9: bus activity while reset is held
        rst_n = 1'b0;
        cyc(3);
        bus_access(1'b1, 8'h40, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, "R9 write in reset");
        bus_access(1'b0, 8'h0C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R9 read in reset");

        // R10: mode pin flipped after reset has no effect
        do_reset(1'b0);
        mode_pin = 1'b1;
        cyc(3);
        bus_access(1'b1, 8'h7E, 1'b1, 8'hD2, 1'b0, 1'b0, 1'b1, 1'b0, "R10 mode held write");
        bus_access(1'b0, 8'h7E, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R10 mode held read");

        check(both_cnt == 0, "R11 read and write together", both_cnt, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule